// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Core

This block arbitrates eight level-sensitive interrupt request lines. Each request is captured every clock into a request register and filtered by a mask register. It is then checked against an in-service register, which records the levels whose handlers are running. The winner is the lowest-numbered eligible level, because level 0 has the highest priority. When a winner exists and no poll is armed, the block raises its interrupt output.

A host drives the block through a synchronous register port. A write either loads the mask or carries a command word. The commands are: clear the highest-priority in-service bit, clear a named in-service bit, turn special mask mode on or off, and arm a single poll. Reads return the request, in-service or mask register. After a poll has been armed, the next read returns a poll word instead, and that read acts as the acknowledge.

The acknowledge strobe moves the current winner from the request register into the in-service register.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the request and in-service registers read 0x00, the mask register reads 0xFF, special mask mode and poll are off, and `irq_out` is low.
- R2: `irq_out` is high one clock after an unmasked request appears, provided nothing blocks it and no poll is armed. Writing the mask with `wr_sel`=0 and bit i set to 1 suppresses level i.
- R3: An `ack` sets the in-service bit of the lowest-numbered eligible level and clears that level's request bit at the same clock edge.
- R4: A set in-service bit blocks its own level and every higher-numbered level from the winner, while lower-numbered levels still raise `irq_out`.
- R5: Command 0x20 (`wr_sel`=1) clears only the lowest-numbered set in-service bit.
- R6: Command 0x60 with bits 2..0 set to L clears exactly in-service bit L. It leaves everything else alone, including when bit L is already clear.
- R7: Command 0x80 turns special mask mode on, and it stays on until command 0xA0. While it is on, a level is blocked only by its own in-service bit.
- R8: Command 0xC0 arms a poll, which holds `irq_out` low. While the poll is armed, `rd_data` shows the poll word: bit 7 is set when an eligible request exists, bits 2..0 hold the winning level, and bits 6..3 are 0. A read with `rd_en` takes that word and sets the winner's in-service bit.
- R9: A poll serves one read only. The next read returns the register chosen by `rd_sel` again.
- R10: When `ack` and command 0x20 fall in the same cycle, both take effect. The clear acts on the in-service value from before the grant.
- R11: An `ack` with no eligible request, whether because there is no request or because the request is masked, leaves the in-service register unchanged.
- R12: `rd_sel` selects 0 = request register, 1 = in-service register, 2 = mask register, and 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Level-sensitive request lines, one per level |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = load mask register, 1 = command word |
| wr_data | input | 8 | Mask value or command word |
| rd_en | input | 1 | Read strobe; consumes an armed poll |
| rd_sel | input | 2 | Register selection for reads |
| rd_data | output | 8 | Selected register, or the poll word while a poll is armed |
| ack | input | 1 | Acknowledge strobe |
| irq_out | output | 1 | Interrupt output |

## Verification
The collision that matters most is a grant and an end-of-interrupt command in the same clock. The grant can come from `ack` or from a poll read. The bench provokes the collision by putting a level in service and then raising a higher-priority request. It then pulses `ack` in the very cycle that carries command 0x20. It judges the result from the in-service register read back afterwards, which must show the old level removed and the new level present. A second overlap is a mask write landing in the same cycle as a grant. By design that grant uses the old mask.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   typedef enum logic [2:0] {
      OP_NOP      = 3'b000,
      OP_EOI_TOP  = 3'b001,
      OP_EOI_LVL  = 3'b011,
      OP_SMM_ON   = 3'b100,
      OP_SMM_OFF  = 3'b101,
      OP_POLL_ARM = 3'b110
   } cmd_op_e;

   typedef struct packed {
      logic mask_wr;
      logic eoi_top;
      logic eoi_lvl;
      logic smm_on;
      logic smm_off;
      logic poll_arm;
   } cmd_t;

   localparam logic [1:0] RSEL_REQ  = 2'd0;
   localparam logic [1:0] RSEL_SVC  = 2'd1;
   localparam logic [1:0] RSEL_MASK = 2'd2;

endpackage

// File: rtl/irq_prio_ffs.sv
module irq_prio_ffs #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [N-1:0]  onehot,
   output logic [IW-1:0] idx,
   output logic          found
);
   // lowest index wins: scan from the top so the last hit is the lowest
   always_comb begin
      onehot = '0;
      idx    = '0;
      found  = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            onehot    = '0;
            onehot[i] = 1'b1;
            idx       = IW'(i);
            found     = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_prio_decode.sv
module irq_prio_decode
   import irq_prio_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LVL_W  = 3
) (
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output cmd_t              cmd,
   output logic [LVL_W-1:0]  lvl_code
);
   cmd_op_e op;

   always_comb begin
      op       = cmd_op_e'(wr_data[DATA_W-1 -: 3]);
      lvl_code = wr_data[LVL_W-1:0];
      cmd      = '0;
      if (wr_en) begin
         if (!wr_sel) begin
            cmd.mask_wr = 1'b1;
         end else begin
            unique case (op)
               OP_EOI_TOP:  cmd.eoi_top  = 1'b1;
               OP_EOI_LVL:  cmd.eoi_lvl  = 1'b1;
               OP_SMM_ON:   cmd.smm_on   = 1'b1;
               OP_SMM_OFF:  cmd.smm_off  = 1'b1;
               OP_POLL_ARM: cmd.poll_arm = 1'b1;
               default:     ;
            endcase
         end
      end
   end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
   parameter int unsigned N           = 8,
   parameter int unsigned LVL_W       = 3,
   parameter bit          SMM_SUPPORT = 1'b1
) (
   input  logic [N-1:0]     irr,
   input  logic [N-1:0]     imr,
   input  logic [N-1:0]     isr,
   input  logic             smm,
   output logic [N-1:0]     win_onehot,
   output logic [LVL_W-1:0] win_idx,
   output logic             win_found
);
   logic [N-1:0] blocked;
   logic [N-1:0] eligible;

   for (genvar i = 0; i < N; i++) begin : g_blk
      if (SMM_SUPPORT) begin : g_relax
         assign blocked[i] = smm ? isr[i] : (|isr[i:0]);
      end else begin : g_strict
         assign blocked[i] = |isr[i:0];
      end
   end

   assign eligible = irr & ~imr & ~blocked;

   irq_prio_ffs #(.N(N), .IW(LVL_W)) u_pick (
      .vec    (eligible),
      .onehot (win_onehot),
      .idx    (win_idx),
      .found  (win_found)
   );

   if (!SMM_SUPPORT) begin : g_unused
      logic smm_unused;
      assign smm_unused = smm;
   end
endmodule

// File: rtl/irq_prio_state.sv
module irq_prio_state
   import irq_prio_pkg::*;
#(
   parameter int unsigned N           = 8,
   parameter int unsigned LVL_W       = 3,
   parameter bit          SMM_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     irq_req,
   input  cmd_t             cmd,
   input  logic [LVL_W-1:0] lvl_code,
   input  logic [N-1:0]     mask_data,
   input  logic             rd_en,
   input  logic             ack,
   input  logic [N-1:0]     win_onehot,
   input  logic             win_found,
   output logic [N-1:0]     irr_q,
   output logic [N-1:0]     isr_q,
   output logic [N-1:0]     imr_q,
   output logic             smm_q,
   output logic             poll_q,
   output logic [N-1:0]     grant
);
   logic [N-1:0] top_clr;
   logic [N-1:0] lvl_clr;
   logic [N-1:0] svc_clr;
   logic [LVL_W-1:0] top_idx_unused;
   logic             top_found_unused;

   irq_prio_ffs #(.N(N), .IW(LVL_W)) u_top_svc (
      .vec    (isr_q),
      .onehot (top_clr),
      .idx    (top_idx_unused),
      .found  (top_found_unused)
   );

   for (genvar i = 0; i < N; i++) begin : g_lvl
      assign lvl_clr[i] = cmd.eoi_lvl && (lvl_code == LVL_W'(i));
   end

   assign svc_clr = (cmd.eoi_top ? top_clr : '0) | lvl_clr;
   assign grant   = ((ack || (rd_en && poll_q)) && win_found) ? win_onehot : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q  <= '0;
         isr_q  <= '0;
         imr_q  <= '1;
         poll_q <= 1'b0;
      end else begin
         irr_q <= irq_req & ~grant;
         isr_q <= (isr_q & ~svc_clr) | grant;
         if (cmd.mask_wr) imr_q <= mask_data;
         if (cmd.poll_arm)  poll_q <= 1'b1;
         else if (rd_en)    poll_q <= 1'b0;
      end
   end

   if (SMM_SUPPORT) begin : g_smm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           smm_q <= 1'b0;
         else if (cmd.smm_on)  smm_q <= 1'b1;
         else if (cmd.smm_off) smm_q <= 1'b0;
      end
   end else begin : g_no_smm
      assign smm_q = 1'b0;
   end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_LEVELS  = 8,
   parameter int unsigned DATA_W      = 8,
   parameter bit          SMM_SUPPORT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] irq_req,
   input  logic                  wr_en,
   input  logic                  wr_sel,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [1:0]            rd_sel,
   output logic [DATA_W-1:0]     rd_data,
   input  logic                  ack,
   output logic                  irq_out
);
   localparam int unsigned LVL_W = $clog2(NUM_LEVELS);

   if (NUM_LEVELS < 2 || NUM_LEVELS > 8 || (1 << LVL_W) != NUM_LEVELS) begin : g_bad_levels
      $error("NUM_LEVELS must be a power of two between 2 and 8");
   end
   if (DATA_W < NUM_LEVELS || DATA_W < LVL_W + 4) begin : g_bad_width
      $error("DATA_W too narrow for register images or command opcodes");
   end

   cmd_t                  cmd;
   logic [LVL_W-1:0]      lvl_code;
   logic [NUM_LEVELS-1:0] irr_q, isr_q, imr_q, grant, win_onehot;
   logic                  smm_q, poll_q, win_found;
   logic [LVL_W-1:0]      win_idx;

   irq_prio_decode #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_decode (
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .cmd      (cmd),
      .lvl_code (lvl_code)
   );

   irq_prio_resolve #(.N(NUM_LEVELS), .LVL_W(LVL_W), .SMM_SUPPORT(SMM_SUPPORT)) u_resolve (
      .irr        (irr_q),
      .imr        (imr_q),
      .isr        (isr_q),
      .smm        (smm_q),
      .win_onehot (win_onehot),
      .win_idx    (win_idx),
      .win_found  (win_found)
   );

   irq_prio_state #(.N(NUM_LEVELS), .LVL_W(LVL_W), .SMM_SUPPORT(SMM_SUPPORT)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_req    (irq_req),
      .cmd        (cmd),
      .lvl_code   (lvl_code),
      .mask_data  (wr_data[NUM_LEVELS-1:0]),
      .rd_en      (rd_en),
      .ack        (ack),
      .win_onehot (win_onehot),
      .win_found  (win_found),
      .irr_q      (irr_q),
      .isr_q      (isr_q),
      .imr_q      (imr_q),
      .smm_q      (smm_q),
      .poll_q     (poll_q),
      .grant      (grant)
   );

   assign irq_out = win_found && !poll_q;

   always_comb begin
      rd_data = '0;
      if (poll_q) begin
         rd_data[DATA_W-1] = win_found;
         if (win_found) rd_data[LVL_W-1:0] = win_idx;
      end else begin
         unique case (rd_sel)
            RSEL_REQ:  rd_data[NUM_LEVELS-1:0] = irr_q;
            RSEL_SVC:  rd_data[NUM_LEVELS-1:0] = isr_q;
            RSEL_MASK: rd_data[NUM_LEVELS-1:0] = imr_q;
            default:   rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
   import irq_prio_pkg::*;
#(
   parameter int unsigned N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         irq_out,
   input logic         rd_en,
   input logic [N-1:0] irr_q,
   input logic [N-1:0] imr_q,
   input logic [N-1:0] isr_q,
   input logic         poll_q,
   input logic [N-1:0] grant,
   input cmd_t         cmd
);
   AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|(irr_q & ~imr_q)));  // R2
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));  // R3
   AST_GRANT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |=> ((isr_q & $past(grant)) == $past(grant)));  // R3
   AST_TOP_EOI_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.eoi_top && grant == '0) |=> (isr_q == ($past(isr_q) & ($past(isr_q) - 1'b1))));  // R5
   AST_POLL_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      poll_q |-> !irq_out);  // R8
   AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && poll_q && !cmd.poll_arm) |=> !poll_q);  // R9
endmodule

bind irq_prio_core irq_prio_chk #(.N(NUM_LEVELS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_out (irq_out),
   .rd_en   (rd_en),
   .irr_q   (irr_q),
   .imr_q   (imr_q),
   .isr_q   (isr_q),
   .poll_q  (poll_q),
   .grant   (grant),
   .cmd     (cmd)
);

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req = '0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [1:0] rd_sel = '0;
   logic [7:0] rd_data;
   logic       ack = 1'b0;
   logic       irq_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_prio_core u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .ack(ack), .irq_out(irq_out)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic put(input logic sel, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic req(input logic [7:0] v);
      @(negedge clk); irq_req = v;
      @(negedge clk);
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      @(negedge clk); rd_en = 1'b1; rd_sel = s;
      #2 v = rd_data;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 irq_out", {7'b0, irq_out}, 8'h00);
      rd(2'd0, v); check("R1 req reg", v, 8'h00);
      rd(2'd1, v); check("R1 svc reg", v, 8'hFF & 8'h00);
      rd(2'd2, v); check("R1 mask reg", v, 8'hFF);
   endtask

   task automatic t_mask();
      put(1'b0, 8'h00);
      req(8'h08);
      check("R2 unmasked raises", {7'b0, irq_out}, 8'h01);
      put(1'b0, 8'h08);
      check("R2 mask suppresses", {7'b0, irq_out}, 8'h00);
      put(1'b0, 8'h00);
   endtask

   task automatic t_priority();
      logic [7:0] v;
      req(8'h28);
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0; rd_en = 1'b1; rd_sel = 2'd0;
      #2 v = rd_data;
      @(negedge clk); rd_en = 1'b0;
      check("R3 winner request cleared", v, 8'h20);
      rd(2'd1, v); check("R3 lowest level in service", v, 8'h08);
      check("R4 lower level blocked", {7'b0, irq_out}, 8'h00);
      req(8'h2A);
      check("R4 higher level passes", {7'b0, irq_out}, 8'h01);
      pulse_ack();
      rd(2'd1, v); check("R4 nested service", v, 8'h0A);
   endtask

   task automatic t_top_eoi();
      logic [7:0] v;
      put(1'b1, 8'h20);
      rd(2'd1, v); check("R5 first clears lowest", v, 8'h08);
      put(1'b1, 8'h20);
      rd(2'd1, v); check("R5 second clears next", v, 8'h00);
      req(8'h00);
   endtask

   task automatic t_lvl_eoi();
      logic [7:0] v;
      req(8'h04); pulse_ack();
      req(8'h01); pulse_ack();
      rd(2'd1, v); check("R6 setup", v, 8'h05);
      put(1'b1, 8'h65);
      rd(2'd1, v); check("R6 clear of idle level no effect", v, 8'h05);
      put(1'b1, 8'h62);
      rd(2'd1, v); check("R6 named level cleared", v, 8'h01);
      put(1'b1, 8'h60);
      rd(2'd1, v); check("R6 level 0 cleared", v, 8'h00);
      req(8'h00);
   endtask

   task automatic t_smm();
      logic [7:0] v;
      put(1'b1, 8'h80);
      req(8'h02); pulse_ack();
      req(8'h12);
      check("R7 lower level passes in special mode", {7'b0, irq_out}, 8'h01);
      pulse_ack();
      rd(2'd1, v); check("R7 lower level served", v, 8'h12);
      put(1'b1, 8'hA0);
      check("R7 mode off blocks again", {7'b0, irq_out}, 8'h00);
      put(1'b1, 8'h20); put(1'b1, 8'h20);
      req(8'h00);
      rd(2'd1, v); check("R7 cleanup", v, 8'h00);
   endtask

   task automatic t_poll();
      logic [7:0] v;
      req(8'h30);
      check("R8 raised before poll", {7'b0, irq_out}, 8'h01);
      put(1'b1, 8'hC0);
      check("R8 poll silences output", {7'b0, irq_out}, 8'h00);
      rd(2'd2, v); check("R8 poll word", v, 8'h84);
      rd(2'd1, v); check("R9 poll spent, normal read", v, 8'h10);
      put(1'b1, 8'h20);
      req(8'h00);
      put(1'b1, 8'hC0);
      rd(2'd2, v); check("R8 empty poll word", v, 8'h00);
      rd(2'd1, v); check("R8 empty poll sets nothing", v, 8'h00);
   endtask

   task automatic t_ack_with_eoi();
      logic [7:0] v;
      req(8'h40); pulse_ack();
      req(8'h44);
      @(negedge clk); ack = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h20;
      @(negedge clk); ack = 1'b0; wr_en = 1'b0;
      rd(2'd1, v); check("R10 grant and clear together", v, 8'h04);
      put(1'b1, 8'h20);
      req(8'h00);
   endtask

   task automatic t_idle_ack();
      logic [7:0] v;
      pulse_ack();
      rd(2'd1, v); check("R11 ack with nothing pending", v, 8'h00);
      put(1'b0, 8'hFF);
      req(8'h01);
      pulse_ack();
      rd(2'd1, v); check("R11 ack with masked request", v, 8'h00);
      check("R11 masked output low", {7'b0, irq_out}, 8'h00);
      req(8'h00);
   endtask

   task automatic t_read_sel();
      logic [7:0] v;
      put(1'b0, 8'h5A);
      rd(2'd2, v); check("R12 mask readback", v, 8'h5A);
      rd(2'd3, v); check("R12 unused select", v, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_priority();
      t_top_eoi();
      t_lvl_eoi();
      t_smm();
      t_poll();
      t_ack_with_eoi();
      t_idle_ack();
      t_read_sel();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule